// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Status Flags

This block is the arithmetic and logic stage of a small eight-bit processor datapath. Each cycle it takes two operands (register and register, or register and immediate, the caller decides), plus an operation code. It produces a result and a next set of status flags. The result is combinational. The six flags (carry, zero, negative, overflow, sign and half carry) live in a status register inside the block. A flag update commits on the clock edge when the enable input is high.

Each operation touches its own subset of flags and leaves the rest alone. The carry input of the carry-chained operations comes from the stored carry flag. The zero flag of the borrow-chained subtractions depends on its previous value, so that a multi-byte subtract or compare leaves zero set only when every byte came out zero. A write strobe tells the register file whether the result should be stored. It is low for the compare operations, for idle cycles and for unused codes.

Top module: `alu8_flags`

## Requirements
- R1: After reset the status register is all zero. Its bit positions are carry 0, zero 1, negative 2, overflow 3, sign 4 and half carry 5.
- R2: Codes 0 (add) and 1 (add plus stored carry) give res = a + b (+ C) modulo 256. They set C to the carry out of bit 7, H to the carry out of bit 3, V to the two's-complement overflow, N to bit 7 of the result and Z to result == 0.
- R3: Codes 2 (subtract) and 4 (compare) give res = a − b. They set C when the unsigned difference borrows, H when bit 4 borrows, V to the signed overflow, N to bit 7 of the result and Z to result == 0.
- R4: Codes 3 (subtract with stored carry) and 5 (compare with stored carry) give res = a − b − C, with C, H, V and N as in R3. Z becomes 0 when the result is nonzero and otherwise keeps its previous value.
- R5: Codes 7 (AND), 8 (OR), 9 (XOR) and 10 (clear bits: a AND NOT b) force V to 0, set N and Z from the result, and leave C and H unchanged.
- R6: Codes 12 (increment) and 13 (decrement) add or subtract one. V is set exactly when increment yields 0x80 or decrement yields 0x7F. N and Z follow the result. C and H are unchanged.
- R7: Code 11 (ones' complement) gives 0xFF − a, sets C to 1, V to 0, N and Z from the result, and keeps H. Code 6 (negate) gives 0x00 − a, with C, H, V, N and Z set as for a subtraction.
- R8: Shift codes act on a. Code 14 shifts left and fills bit 0 with 0. Code 15 shifts right and fills bit 7 with 0. Code 16 rotates left through C. Code 17 rotates right through C. Code 18 shifts right arithmetically and keeps bit 7. In each case C takes the bit shifted out, V = N XOR C, N and Z follow the result, and H is unchanged.
- R9: Code 19 swaps the two nibbles of a and changes no flag.
- R10: After every operation that updates flags (every defined code except 19), S = N XOR V.
- R11: With en_i low, or with codes 20 to 31, the flags hold. With codes 20 to 31 the result is 0. wr_o is high only when en_i is high and the code is 0 to 3 or 6 to 19.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Commit this operation's flag update |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Destination-side operand |
| b_i | input | 8 | Source operand or immediate |
| res_o | output | 8 | Combinational result |
| wr_o | output | 1 | Result should be written back |
| flags_o | output | 6 | Registered status flags |

## Verification
The assertions assume that op_i, a_i and b_i carry known values whenever en_i is high. They also assume that these inputs are stable across the sampling edge. The flag-hold properties further assume that reset is not pulsed mid-run. The bench changes every input only on the falling clock edge and always drives defined values. Before each swept vector it runs a preparation operation that puts the stored carry and zero flags into a chosen combination. This means the carry-in and chained-zero paths are exercised in all four states without any value outside the defined input set.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_CPC  = 5'd5,
        OP_NEG  = 5'd6,
        OP_AND  = 5'd7,
        OP_OR   = 5'd8,
        OP_XOR  = 5'd9,
        OP_CBR  = 5'd10,
        OP_COM  = 5'd11,
        OP_INC  = 5'd12,
        OP_DEC  = 5'd13,
        OP_LSL  = 5'd14,
        OP_LSR  = 5'd15,
        OP_ROL  = 5'd16,
        OP_ROR  = 5'd17,
        OP_ASR  = 5'd18,
        OP_SWAP = 5'd19
    } alu_op_e;

    // packed MSB first: c lands on bit 0, h on bit 5
    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    localparam int unsigned FLAG_W = $bits(flags_t);

    function automatic logic is_logic_op(input logic [4:0] op);
        return op inside {OP_AND, OP_OR, OP_XOR, OP_CBR};
    endfunction

    function automatic logic is_shift_op(input logic [4:0] op);
        return op inside {OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR};
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         c_o,
    output logic         h_o,
    output logic         v_o
);
    localparam int unsigned HW = W / 2;

    logic [W:0]  full;
    logic [HW:0] half;

    always_comb begin
        if (sub_i) begin
            full = {1'b0, a_i} - {1'b0, b_i} - (W+1)'(cin_i);
            half = {1'b0, a_i[HW-1:0]} - {1'b0, b_i[HW-1:0]} - (HW+1)'(cin_i);
        end else begin
            full = {1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i);
            half = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + (HW+1)'(cin_i);
        end
    end

    assign sum_o = full[W-1:0];
    // top bit is carry for add and borrow for subtract
    assign c_o   = full[W];
    assign h_o   = half[HW];

    always_comb begin
        if (sub_i)
            v_o = (a_i[W-1] ^ b_i[W-1]) & (a_i[W-1] ^ full[W-1]);
        else
            v_o = ~(a_i[W-1] ^ b_i[W-1]) & (a_i[W-1] ^ full[W-1]);
    end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [4:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    localparam int unsigned HW = W / 2;

    logic [W-1:0] swapped;

    genvar gi;
    generate
        for (gi = 0; gi < HW; gi++) begin : g_swap
            assign swapped[gi]      = a_i[gi + HW];
            assign swapped[gi + HW] = a_i[gi];
        end
    endgenerate

    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_CBR:  res_o = a_i & ~b_i;
            OP_COM:  res_o = ~a_i;
            OP_SWAP: res_o = swapped;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [4:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);
    always_comb begin
        res_o = '0;
        c_o   = 1'b0;
        unique case (op_i)
            OP_LSL: begin res_o = {a_i[W-2:0], 1'b0};     c_o = a_i[W-1]; end
            OP_LSR: begin res_o = {1'b0, a_i[W-1:1]};     c_o = a_i[0];   end
            OP_ROL: begin res_o = {a_i[W-2:0], cin_i};    c_o = a_i[W-1]; end
            OP_ROR: begin res_o = {cin_i, a_i[W-1:1]};    c_o = a_i[0];   end
            OP_ASR: begin res_o = {a_i[W-1], a_i[W-1:1]}; c_o = a_i[0];   end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic [4:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         wr_o,
    output logic [5:0]   flags_o
);
    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cin;
        logic         sub;
    } arith_sel_t;

    typedef struct packed {
        flags_t       flags;
        logic [W-1:0] res;
        logic         wr;
    } nxt_t;

    flags_t       flags_q;
    nxt_t         nxt_d;
    arith_sel_t   sel_d;
    logic [W-1:0] as_sum, bw_res, sh_res;
    logic         as_c, as_h, as_v, sh_c;

    // operand selection for the shared adder/subtractor
    always_comb begin
        sel_d.a   = a_i;
        sel_d.b   = b_i;
        sel_d.cin = 1'b0;
        sel_d.sub = 1'b0;
        unique case (op_i)
            OP_ADC: sel_d.cin = flags_q.c;
            OP_SUB, OP_CMP: sel_d.sub = 1'b1;
            OP_SBC, OP_CPC: begin sel_d.sub = 1'b1; sel_d.cin = flags_q.c; end
            OP_NEG: begin sel_d.sub = 1'b1; sel_d.a = '0; sel_d.b = a_i; end
            OP_INC: sel_d.b = W'(1);
            OP_DEC: begin sel_d.sub = 1'b1; sel_d.b = W'(1); end
            default: ;
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a_i   (sel_d.a),
        .b_i   (sel_d.b),
        .cin_i (sel_d.cin),
        .sub_i (sel_d.sub),
        .sum_o (as_sum),
        .c_o   (as_c),
        .h_o   (as_h),
        .v_o   (as_v)
    );

    alu8_bitwise #(.W(W)) u_bitwise (
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (bw_res)
    );

    alu8_shifter #(.W(W)) u_shifter (
        .op_i  (op_i),
        .a_i   (a_i),
        .cin_i (flags_q.c),
        .res_o (sh_res),
        .c_o   (sh_c)
    );

    // next-value process
    always_comb begin
        flags_t f;
        logic   upd;
        f         = flags_q;
        upd       = 1'b1;
        nxt_d.res = '0;
        unique case (op_i)
            OP_ADD, OP_ADC, OP_SUB, OP_CMP, OP_NEG: begin
                nxt_d.res = as_sum;
                f.c = as_c;
                f.h = as_h;
                f.v = as_v;
                f.z = (as_sum == '0);
            end
            OP_SBC, OP_CPC: begin
                nxt_d.res = as_sum;
                f.c = as_c;
                f.h = as_h;
                f.v = as_v;
                f.z = (as_sum == '0) & flags_q.z;
            end
            OP_INC, OP_DEC: begin
                nxt_d.res = as_sum;
                f.v = as_v;
                f.z = (as_sum == '0);
            end
            OP_AND, OP_OR, OP_XOR, OP_CBR: begin
                nxt_d.res = bw_res;
                f.v = 1'b0;
                f.z = (bw_res == '0);
            end
            OP_COM: begin
                nxt_d.res = bw_res;
                f.c = 1'b1;
                f.v = 1'b0;
                f.z = (bw_res == '0);
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                nxt_d.res = sh_res;
                f.c = sh_c;
                f.v = sh_res[W-1] ^ sh_c;
                f.z = (sh_res == '0);
            end
            OP_SWAP: begin
                nxt_d.res = bw_res;
                upd = 1'b0;
            end
            default: upd = 1'b0;
        endcase
        if (upd) begin
            f.n = nxt_d.res[W-1];
            f.s = f.n ^ f.v;
        end
        nxt_d.flags = en_i ? f : flags_q;
        nxt_d.wr    = en_i && (op_i <= OP_SWAP) && !(op_i inside {OP_CMP, OP_CPC});
    end

    // register process
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flags_q <= '0;
        else         flags_q <= nxt_d.flags;
    end

    assign res_o   = nxt_d.res;
    assign wr_o    = nxt_d.wr;
    assign flags_o = flags_q;

    // ---------------------------------------------------------------
    assert_hold_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i || op_i > OP_SWAP) |=> flags_o == $past(flags_o));

    assert_swap_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && op_i == OP_SWAP) |=> flags_o == $past(flags_o));

    assert_logic_keeps_ch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && is_logic_op(op_i)) |=>
            (flags_o[0] == $past(flags_o[0])) && (flags_o[5] == $past(flags_o[5])) && !flags_o[3]);

    assert_chain_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && (op_i == OP_SBC || op_i == OP_CPC) && !flags_o[1]) |=> !flags_o[1]);

    assert_shift_ovf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && is_shift_op(op_i)) |=> flags_o[3] == (flags_o[2] ^ flags_o[0]));

    assert_add_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && op_i == OP_ADD) |-> res_o == W'(a_i + b_i));

    assert_sign_parity_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && op_i < OP_SWAP) |=> flags_o[4] == (flags_o[2] ^ flags_o[3]));

    assert_cmp_no_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_CMP) |-> !wr_o);

endmodule

// File: tb/alu8_flags_tb_top.sv
`timescale 1ns/1ps
module alu8_flags_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic [4:0] op;
    logic [7:0] a, b;
    logic [7:0] res;
    logic       wr;
    logic [5:0] flags;

    int         n_vec = 0;
    int         n_bad = 0;
    logic [5:0] exp_f = '0;
    bit         done  = 0;

    always #2.5 clk = ~clk;

    alu8_flags dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .en_i    (en),
        .op_i    (op),
        .a_i     (a),
        .b_i     (b),
        .res_o   (res),
        .wr_o    (wr),
        .flags_o (flags)
    );

    function automatic string req_of(input int o);
        case (o)
            0, 1:          return "R2";
            2, 4:          return "R3";
            3, 5:          return "R4";
            7, 8, 9, 10:   return "R5";
            12, 13:        return "R6";
            6, 11:         return "R7";
            14, 15, 16, 17, 18: return "R8";
            19:            return "R9";
            default:       return "R11";
        endcase
    endfunction

    // reference model: flag bits c0 z1 n2 v3 s4 h5
    function automatic void model(input int o, input int x, input int y, input logic [5:0] f,
                                  output int r, output logic w, output logic [5:0] nf);
        int   t, ci;
        logic c, z, n, v, h, upd;
        c = f[0]; z = f[1]; n = f[2]; v = f[3]; h = f[5];
        upd = 1; r = 0;
        case (o)
            0, 1: begin
                ci = (o == 1) ? int'(f[0]) : 0;
                t = x + y + ci; r = t & 255;
                c = (t > 255); h = (((x & 15) + (y & 15) + ci) > 15);
                v = (((x ^ r) & (y ^ r) & 128) != 0); z = (r == 0);
            end
            2, 3, 4, 5, 6: begin
                int p, q;
                p = (o == 6) ? 0 : x; q = (o == 6) ? x : y;
                ci = (o == 3 || o == 5) ? int'(f[0]) : 0;
                t = p - q - ci; r = t & 255;
                c = (t < 0); h = (((p & 15) - (q & 15) - ci) < 0);
                v = (((p ^ q) & (p ^ r) & 128) != 0);
                z = (r == 0) && ((o == 3 || o == 5) ? f[1] : 1'b1);
            end
            7, 8, 9, 10: begin
                r = (o == 7) ? (x & y) : (o == 8) ? (x | y) : (o == 9) ? (x ^ y) : (x & (255 - y));
                v = 0; z = (r == 0);
            end
            11: begin r = 255 - x; c = 1; v = 0; z = (r == 0); end
            12, 13: begin
                r = (o == 12) ? ((x + 1) & 255) : ((x + 255) & 255);
                v = (o == 12) ? (r == 128) : (r == 127); z = (r == 0);
            end
            14, 15, 16, 17, 18: begin
                case (o)
                    14: begin r = (x * 2) & 255;               c = (x >= 128); end
                    15: begin r = x / 2;                       c = x[0];       end
                    16: begin r = ((x * 2) & 255) + int'(f[0]); c = (x >= 128); end
                    17: begin r = x / 2 + 128 * int'(f[0]);    c = x[0];       end
                    default: begin r = x / 2 + (x & 128);      c = x[0];       end
                endcase
                z = (r == 0); v = (r >= 128) ^ c;
            end
            19: begin r = ((x % 16) * 16) + (x / 16); upd = 0; end
            default: begin r = 0; upd = 0; end
        endcase
        if (upd) begin
            n = (r >= 128);
            nf = {h, n ^ v, v, n, z, c};
        end else begin
            nf = f;
        end
        w = (o <= 19) && (o != 4) && (o != 5);
    endfunction

    task automatic fail(input string tag, input string what, input int act, input int expv);
        n_bad++;
        $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    endtask

    task automatic apply(input int o, input int x, input int y, input logic e);
        int         r;
        logic       w;
        logic [5:0] nf;
        @(negedge clk);
        en = e; op = o[4:0]; a = x[7:0]; b = y[7:0];
        model(o, x, y, exp_f, r, w, nf);
        if (!e) nf = exp_f;
        w = w & e;
        #1;
        n_vec++;
        if (res !== r[7:0]) fail(req_of(o), "result", int'(res), r);
        n_vec++;
        if (wr !== w) fail("R11", "write strobe", int'(wr), int'(w));
        @(posedge clk);
        #1;
        n_vec++;
        if (flags !== nf) fail(e ? req_of(o) : "R11", "flags", int'(flags), int'(nf));
        if (e && o < 19) begin
            n_vec++;
            if (flags[4] !== (nf[2] ^ nf[3])) fail("R10", "sign flag", int'(flags[4]), int'(nf[2] ^ nf[3]));
        end
        exp_f = nf;
    endtask

    // put carry and zero into a chosen state
    task automatic prep(input int cz);
        case (cz)
            0: apply(0, 1, 0, 1'b1);      // c0 z0
            1: apply(0, 0, 0, 1'b1);      // c0 z1
            2: apply(2, 0, 1, 1'b1);      // c1 z0
            default: apply(14, 128, 0, 1'b1); // c1 z1
        endcase
    endtask

    function automatic int pick_b(input int i, input int x);
        case (i)
            0: return 0;
            1: return 1;
            2: return 15;
            3: return 127;
            4: return 128;
            5: return 255;
            6: return x;
            default: return (x * 29 + 71) & 255;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; op = '0; a = '0; b = '0;
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if (flags !== 6'b0) fail("R1", "reset flags", int'(flags), 0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_f = '0;

        // R4 chained zero: stays set on zero, clears on nonzero, never re-set
        prep(1);
        apply(3, 5, 5, 1'b1);
        apply(3, 6, 5, 1'b1);
        apply(5, 9, 9, 1'b1);
        // R11: idle cycles and unused codes hold the flags
        prep(2);
        apply(0, 255, 1, 1'b0);
        apply(23, 255, 1, 1'b1);
        apply(31, 0, 0, 1'b1);

        // sweep: every code, all a, eight b, rotating carry/zero state
        for (int o = 0; o < 22; o++) begin
            for (int x = 0; x < 256; x++) begin
                for (int i = 0; i < 8; i++) begin
                    prep((x + i + o) & 3);
                    apply(o, x, pick_b(i, x), 1'b1);
                end
            end
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule